// File: doc/BRIEF.md
# Piecewise Gamma Code Interpolator

This block turns a 6-bit gray code into an output level by piecewise-linear interpolation between eleven programmable reference levels. It is the digital model of a gamma-corrected display converter. Software or a sequencer loads the eleven references through a write port, one index at a time. After that, each accepted code gives one registered output level one clock later.

The 64 codes fall into unequal segments. Each end code maps straight onto its outer reference. The two segments next to the ends split their span into seven steps, and the six inner segments split theirs into eight. The references may form a falling ladder or a rising one. Interpolation is a weighted sum of the two references of a pair, so both orderings give correct results. Eighths are exact before rounding. Sevenths are rounded to the nearest integer.

Top module: `gamma_interp`

## Requirements
- R1: During reset and after it, `out_valid` and `out_level` are 0 and all eleven references read as 0.
- R2: Code 0x00 gives reference 0 exactly, and code 0x3F gives reference 10 exactly.
- R3: For codes 0x08 to 0x37, let u be bits [5:3] and k be bits [2:0]. The upper level is H = ref[u+1] and the lower level is L = ref[u+2]. The output is L + (H − L)·(8 − k)/8, so code 0x08 gives ref[2] and code 0x0F gives ref[3] + (ref[2] − ref[3])/8.
- R4: Codes 0x01 to 0x07 give ref[2] + (ref[1] − ref[2])·(8 − code)/7, so code 0x01 gives ref[1]. Codes 0x38 to 0x3E give ref[9] + (ref[8] − ref[9])·(0x3F − code)/7, so code 0x38 gives ref[8].
- R5: A fractional result is rounded to the nearest integer, with a half rounded up, that is floor(x + 1/2). The output never leaves the range spanned by its two references.
- R6: R2 to R5 hold for a falling ladder (ref[0] largest) and for a rising ladder (ref[0] smallest), with no restriction on reference order.
- R7: `out_valid` equals `in_valid` from one clock earlier. `out_level` changes only in the cycle after an accepted code and holds its value otherwise.
- R8: A write with `ref_we` high and `ref_idx` from 0 to 10 loads `ref_wdata` into that reference. A code accepted in the same cycle still uses the old value, and codes from the next cycle on use the new one.
- R9: A write with `ref_idx` from 11 to 15 changes no reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_we | input | 1 | Reference write strobe |
| ref_idx | input | 4 | Reference index, 0 to 10 valid |
| ref_wdata | input | LVL_W | Reference value to store |
| in_valid | input | 1 | Code present this cycle |
| in_code | input | 6 | Gray code |
| out_valid | output | 1 | Registered valid, one clock after `in_valid` |
| out_level | output | LVL_W | Interpolated level |

## Verification
The bench sweeps all 64 codes on a falling ladder and on a rising ladder. A design that sign-extended the difference wrongly would give wrong levels only on the rising ladder. It drives small reference spans where sevenths land on and near half steps. A design that truncated would come out one low, and one that mixed up the seven-step and eight-step segments would be off next to the ends. It also writes a reference in the same cycle as a code that reads it, writes to the five unused indices, and leaves gaps in `in_valid`. These catch a bypassed write, an aliased index and an output that drifts while idle. A long random mix of writes and codes is then checked every clock against a behavioural model.

// File: rtl/gamma_interp_pkg.sv
`timescale 1ns/1ps
package gamma_interp_pkg;
   localparam int NUM_REFS = 11;
   localparam int IDX_W    = 4;
   localparam int CODE_W   = 6;
   localparam int WT_W     = 4;

   typedef logic [IDX_W-1:0] ref_idx_t;

   typedef struct packed {
      ref_idx_t        hi_idx;
      ref_idx_t        lo_idx;
      logic [WT_W-1:0] weight;
      logic            by_seven;
   } seg_sel_t;
endpackage

// File: rtl/gamma_seg_decode.sv
`timescale 1ns/1ps
module gamma_seg_decode
   import gamma_interp_pkg::*;
(
   input  logic [CODE_W-1:0] code,
   output seg_sel_t          sel
);
   logic [2:0] seg;
   logic [2:0] step;

   assign seg  = code[5:3];
   assign step = code[2:0];

   always_comb begin
      sel = '0;
      unique case (seg)
         3'd0: begin
            if (step == 3'd0) begin
               sel.hi_idx   = ref_idx_t'(0);
               sel.lo_idx   = ref_idx_t'(0);
               sel.weight   = 4'd8;
               sel.by_seven = 1'b0;
            end else begin
               sel.hi_idx   = ref_idx_t'(1);
               sel.lo_idx   = ref_idx_t'(2);
               sel.weight   = 4'd8 - {1'b0, step};
               sel.by_seven = 1'b1;
            end
         end
         3'd7: begin
            if (step == 3'd7) begin
               sel.hi_idx   = ref_idx_t'(10);
               sel.lo_idx   = ref_idx_t'(10);
               sel.weight   = 4'd8;
               sel.by_seven = 1'b0;
            end else begin
               sel.hi_idx   = ref_idx_t'(8);
               sel.lo_idx   = ref_idx_t'(9);
               sel.weight   = 4'd7 - {1'b0, step};
               sel.by_seven = 1'b1;
            end
         end
         default: begin
            sel.hi_idx   = ref_idx_t'({1'b0, seg}) + ref_idx_t'(1);
            sel.lo_idx   = ref_idx_t'({1'b0, seg}) + ref_idx_t'(2);
            sel.weight   = 4'd8 - {1'b0, step};
            sel.by_seven = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/gamma_ref_bank.sv
`timescale 1ns/1ps
module gamma_ref_bank
   import gamma_interp_pkg::*;
#(
   parameter int LVL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  ref_idx_t         wr_idx,
   input  logic [LVL_W-1:0] wr_val,
   input  ref_idx_t         rd_a_idx,
   input  ref_idx_t         rd_b_idx,
   output logic [LVL_W-1:0] rd_a,
   output logic [LVL_W-1:0] rd_b
);
   localparam int FLAT_W = NUM_REFS * LVL_W;

   logic [LVL_W-1:0]  lvl_q [NUM_REFS];
   logic [FLAT_W-1:0] lvl_flat;

   for (genvar i = 0; i < NUM_REFS; i++) begin : g_ref
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lvl_q[i] <= '0;
         else if (wr_en && (wr_idx == ref_idx_t'(i)))
            lvl_q[i] <= wr_val;
      end
      assign lvl_flat[i*LVL_W +: LVL_W] = lvl_q[i];
   end

   always_comb begin
      rd_a = '0;
      rd_b = '0;
      for (int j = 0; j < NUM_REFS; j++) begin
         if (rd_a_idx == ref_idx_t'(j)) rd_a = lvl_q[j];
         if (rd_b_idx == ref_idx_t'(j)) rd_b = lvl_q[j];
      end
   end

   // R9: out-of-range index leaves every stored reference untouched
   a_r9_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx >= ref_idx_t'(NUM_REFS))) |=> $stable(lvl_flat));

   // R8: an in-range write lands in the addressed entry
   a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx == ref_idx_t'(0))) |=> (lvl_flat[LVL_W-1:0] == $past(wr_val)));

   // R8: no write leaves the whole bank unchanged
   a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(lvl_flat));
endmodule

// File: rtl/gamma_blend.sv
`timescale 1ns/1ps
module gamma_blend
   import gamma_interp_pkg::*;
#(
   parameter int LVL_W      = 10,
   parameter bit RECIP_DIV7 = 1'b1
) (
   input  logic [LVL_W-1:0] hi_lvl,
   input  logic [LVL_W-1:0] lo_lvl,
   input  logic [WT_W-1:0]  weight,
   input  logic             by_seven,
   output logic [LVL_W-1:0] level
);
   localparam int SUM_W = LVL_W + WT_W;
   localparam int NUM_W = SUM_W + 1;
   localparam int Q_W   = NUM_W - 3;
   localparam int SH    = NUM_W + 4;
   localparam int MUL_W = SH - 3;
   localparam longint unsigned MUL_K = ((64'd1 << SH) + 64'd13) / 64'd14;

   if (LVL_W < 2 || LVL_W > 24) begin : g_bad_width
      $error("gamma_blend: LVL_W out of supported range 2..24");
   end

   logic [WT_W-1:0]  denom;
   logic [WT_W-1:0]  comp;
   logic [SUM_W-1:0] total;
   logic [SUM_W-1:0] eighth_full;
   logic [NUM_W-1:0] num7;
   logic [Q_W-1:0]   seventh_full;

   assign denom = by_seven ? 4'd7 : 4'd8;
   assign comp  = denom - weight;
   assign total = SUM_W'(hi_lvl) * SUM_W'(weight) + SUM_W'(lo_lvl) * SUM_W'(comp);

   // eighths: add half a step then drop three fraction bits
   assign eighth_full = (total + SUM_W'(4)) >> 3;
   // sevenths: floor((2*total + 7) / 14)
   assign num7 = {total, 1'b0} + NUM_W'(7);

   if (RECIP_DIV7) begin : g_recip
      logic [NUM_W+MUL_W-1:0] prod;
      logic [SH-1:0]          unused_low;
      assign prod         = (NUM_W+MUL_W)'(num7) * (NUM_W+MUL_W)'(MUL_K[MUL_W-1:0]);
      assign seventh_full = prod[SH +: Q_W];
      assign unused_low   = prod[SH-1:0];
   end else begin : g_direct
      logic [NUM_W-1:0] quo;
      assign quo          = num7 / NUM_W'(14);
      assign seventh_full = quo[Q_W-1:0];
   end

   logic [SUM_W-LVL_W-1:0] unused_e;
   logic [Q_W-LVL_W-1:0]   unused_s;
   assign unused_e = eighth_full[SUM_W-1:LVL_W];
   assign unused_s = seventh_full[Q_W-1:LVL_W];

   assign level = by_seven ? seventh_full[LVL_W-1:0] : eighth_full[LVL_W-1:0];
endmodule

// File: rtl/gamma_interp.sv
`timescale 1ns/1ps
module gamma_interp
   import gamma_interp_pkg::*;
#(
   parameter int LVL_W      = 10,
   parameter bit RECIP_DIV7 = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_we,
   input  logic [3:0]       ref_idx,
   input  logic [LVL_W-1:0] ref_wdata,
   input  logic             in_valid,
   input  logic [5:0]       in_code,
   output logic             out_valid,
   output logic [LVL_W-1:0] out_level
);
   if (IDX_W != 4 || CODE_W != 6) begin : g_bad_pkg
      $error("gamma_interp: package widths do not match the port list");
   end

   seg_sel_t         sel;
   logic [LVL_W-1:0] hi_val;
   logic [LVL_W-1:0] lo_val;
   logic [LVL_W-1:0] mix;

   gamma_seg_decode u_dec (
      .code (in_code),
      .sel  (sel)
   );

   gamma_ref_bank #(.LVL_W(LVL_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ref_we),
      .wr_idx   (ref_idx),
      .wr_val   (ref_wdata),
      .rd_a_idx (sel.hi_idx),
      .rd_b_idx (sel.lo_idx),
      .rd_a     (hi_val),
      .rd_b     (lo_val)
   );

   gamma_blend #(.LVL_W(LVL_W), .RECIP_DIV7(RECIP_DIV7)) u_blend (
      .hi_lvl   (hi_val),
      .lo_lvl   (lo_val),
      .weight   (sel.weight),
      .by_seven (sel.by_seven),
      .level    (mix)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_level <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_level <= mix;
      end
   end

   // R7: valid trails input valid by exactly one clock
   a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)));

   // R7: idle cycles keep the level
   a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_level));

   // R2: end codes return their reference exactly
   a_r2_low_end: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_code == 6'h00) |=> (out_level == $past(u_bank.lvl_q[0])));

   a_r2_high_end: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_code == 6'h3F) |=> (out_level == $past(u_bank.lvl_q[10])));

   // R5: result stays inside the span of its pair
   a_r5_within_pair: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((out_level >= (($past(hi_val) < $past(lo_val)) ? $past(hi_val) : $past(lo_val))) &&
                    (out_level <= (($past(hi_val) > $past(lo_val)) ? $past(hi_val) : $past(lo_val)))));

   // R4: seven-step segments use weights 1..7 on adjacent references
   a_r4_seven_pair: assert property (@(posedge clk) disable iff (!rst_n)
      sel.by_seven |-> ((sel.lo_idx == sel.hi_idx + ref_idx_t'(1)) && (sel.weight != 4'd0) && (sel.weight <= 4'd7)));
endmodule

// File: tb/sim_gamma_interp.sv
`timescale 1ns/1ps
module sim_gamma_interp;
   localparam int LW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_we = 1'b0;
   logic [3:0]    ref_idx = '0;
   logic [LW-1:0] ref_wdata = '0;
   logic          in_valid = 1'b0;
   logic [5:0]    in_code = '0;
   logic          out_valid;
   logic [LW-1:0] out_level;

   always #2.5 clk = ~clk;

   gamma_interp #(.LVL_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_we(ref_we), .ref_idx(ref_idx), .ref_wdata(ref_wdata),
      .in_valid(in_valid), .in_code(in_code), .out_valid(out_valid), .out_level(out_level)
   );

   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 0;
   string phase = "R1 reset";

   int    refm [11];
   bit    exp_v = 0;
   int    exp_l = 0;
   string exp_tag = "R1";

   // behavioural model taken from R2..R5
   function automatic int model(input int code);
      int u, k, h, l, m, d;
      u = code / 8; k = code % 8;
      if (code == 0)  return refm[0];
      if (code == 63) return refm[10];
      if (u == 0)      begin h = refm[1]; l = refm[2]; m = 8 - code; d = 7; end
      else if (u == 7) begin h = refm[8]; l = refm[9]; m = 63 - code; d = 7; end
      else             begin h = refm[u+1]; l = refm[u+2]; m = 8 - k; d = 8; end
      return (2 * (l * (d - m) + h * m) + d) / (2 * d);
   endfunction

   function automatic string region(input int code);
      if (code == 0 || code == 63) return "R2";
      if (code < 8 || code >= 56)  return "R4";
      return "R3";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (refm[i]) refm[i] = 0;
         exp_v = 0; exp_l = 0;
      end else begin
         if (in_valid) begin exp_l = model(int'(in_code)); exp_tag = region(int'(in_code)); end
         else exp_tag = "R7";
         exp_v = in_valid;
         if (ref_we && ref_idx < 4'd11) refm[ref_idx] = int'(ref_wdata);
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            n_run++;
            if (out_valid !== 1'b0 || out_level !== '0) begin
               n_fail++;
               $display("FAIL R1 reset: valid=%0b level=%0d expected 0/0", out_valid, out_level);
            end
         end else begin
            n_run++;
            if (out_valid !== exp_v) begin
               n_fail++;
               $display("FAIL R7 [%s] valid got %0b expected %0b", phase, out_valid, exp_v);
            end
            n_run++;
            if (int'(out_level) != exp_l) begin
               n_fail++;
               $display("FAIL %s [%s] level got %0d expected %0d", exp_tag, phase, out_level, exp_l);
            end
         end
      end
   end

   task automatic drive(input bit we, input int idx, input int val, input bit v, input int code);
      @(negedge clk);
      ref_we = we; ref_idx = 4'(idx); ref_wdata = LW'(val);
      in_valid = v; in_code = 6'(code);
   endtask

   task automatic load(input int vals [11]);
      for (int i = 0; i < 11; i++) drive(1'b1, i, vals[i], 1'b0, 0);
      drive(1'b0, 0, 0, 1'b0, 0);
   endtask

   task automatic sweep(input bit gaps);
      for (int c = 0; c < 64; c++) begin
         drive(1'b0, 0, 0, 1'b1, c);
         if (gaps) begin drive(1'b0, 0, 0, 1'b0, 63 - c); drive(1'b0, 0, 0, 1'b0, 0); end
      end
      drive(1'b0, 0, 0, 1'b0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog expired");
      finish_run();
   end

   initial begin
      int fall [11] = '{1000, 950, 880, 790, 700, 600, 520, 430, 330, 200, 10};
      int rise [11] = '{5, 41, 130, 222, 317, 409, 515, 601, 713, 850, 1023};
      int tiny [11] = '{0, 3, 0, 11, 4, 0, 9, 1, 0, 5, 2};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      phase = "R1 zero refs";
      drive(1'b0, 0, 0, 1'b1, 0); drive(1'b0, 0, 0, 1'b1, 63); drive(1'b0, 0, 0, 1'b1, 20);
      drive(1'b0, 0, 0, 1'b0, 0);

      phase = "R3 R4 falling"; load(fall); sweep(1'b0);
      phase = "R7 gaps";       sweep(1'b1);
      phase = "R6 rising";     load(rise); sweep(1'b0);
      phase = "R5 rounding";   load(tiny); sweep(1'b0);

      phase = "R9 bad index";
      load(fall);
      for (int i = 11; i < 16; i++) drive(1'b1, i, 1023 - i, 1'b0, 0);
      drive(1'b0, 0, 0, 1'b0, 0);
      sweep(1'b0);

      phase = "R8 same cycle";
      drive(1'b1, 0, 500, 1'b1, 0);
      drive(1'b1, 10, 77, 1'b1, 0);
      drive(1'b0, 0, 0, 1'b1, 63);
      drive(1'b1, 1, 612, 1'b1, 1);
      drive(1'b0, 0, 0, 1'b1, 1);
      drive(1'b0, 0, 0, 1'b0, 0);

      phase = "random";
      for (int n = 0; n < 3000; n++)
         drive(($urandom_range(0, 3) == 0), $urandom_range(0, 15), $urandom_range(0, 1023),
               ($urandom_range(0, 3) != 0), $urandom_range(0, 63));
      drive(1'b0, 0, 0, 1'b0, 0);
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule